// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block sits between two independent access ports and a shared byte-wide storage array. Each port has an enable, an active-low write strobe, an address, write data and registered read data. When both ports are enabled and present the same address in the same cycle, the block picks one port to own the location. It pulls the other port's active-low busy output low and suppresses that port's writes, so the array cannot be corrupted by the losing side.

Arrival is judged per clock cycle. A port counts as "already there" if it was enabled at the same address in the previous cycle. When a collision first appears, a port that was already there beats a port that has just moved in. If both ports move in during the same cycle, the left port wins by fixed rule. Reads from a busy port are not blocked; they return whatever the array holds and are only flagged. A combined collision flag is provided so the event can be routed to an error interrupt.

Top module: `dpca_top`

## Requirements
- R1: With either enable low, or with both enabled at different addresses, both busy outputs are high in that cycle.
- R2: When a collision begins and one port was enabled at that same address in the previous cycle while the other was not, the newcomer's busy output goes low and the incumbent's stays high.
- R3: The two busy outputs are never low together.
- R4: When a collision begins and neither port, or both ports after moving together, qualify as incumbent, the right busy goes low and the left busy stays high.
- R5: A write (enable high, write strobe low) from a port whose busy is low leaves the addressed array byte unchanged; a write from a port whose busy is high stores its data at the clock edge.
- R6: Busy is released combinationally in the cycle in which the addresses stop matching or either enable drops.
- R7: While both ports keep the same enable and address from cycle to cycle, the winner of the collision does not change.
- R8: A busy port performing a read (enable high, write strobe high) still gets the array byte in its read data one clock later, as it stood before that edge's writes.
- R9: The collision output is high exactly when one of the busy outputs is low.
- R10: Read data updates only on an edge with enable high and write strobe high, to the array byte at the address; after reset it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_en | input | 1 | Left port enable |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_n | output | 1 | Left busy, active low |
| r_en | input | 1 | Right port enable |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_n | output | 1 | Right busy, active low |
| collide | output | 1 | High when either port is busy |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. The 64-byte array can be filled completely at the start, so every read afterwards has a known expected value. The random phase confines both ports to four addresses, which makes collisions, incumbents, newcomers, same-cycle ties and releases frequent. Directed sequences cover the incumbent on each side, a tie from idle, both ports moving together to a fresh address, and release by address change and by enable drop.

// File: rtl/dpca_pkg.sv
// Shared types for the dual-port collision arbiter.
// Assumes nothing beyond being compiled first.
package dpca_pkg;
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpca_arrival_tracker.sv
// Remembers a port's enable and address from the previous cycle and reports
// whether the port is "holding": enabled now at the same address it was
// enabled at one cycle ago. Assumes a synchronous active-low reset.
module dpca_arrival_tracker #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture the previous cycle's enable and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // Holding means the same enabled address on two consecutive cycles.
    always_comb begin
        held = en && en_q && (addr == addr_q);
    end

    // R7: holding implies the port was enabled at the same address last cycle.
    p_held_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> ($past(en) && $past(addr) == addr));
endmodule

// File: rtl/dpca_contention.sv
// Detects a same-address collision between two enabled ports and decides the
// owner: a holding port beats a newcomer, a tie goes to the left port, and an
// ongoing collision keeps its owner while both ports hold. Busy outputs are
// combinational in the current inputs and the stored owner.
module dpca_contention
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_held,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_held,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              collide
);
    side_e owner_q;
    side_e winner;
    logic  match;

    // Live collision: both enabled on the same location.
    always_comb begin
        match = l_en && r_en && (l_addr == r_addr);
    end

    // Pick this cycle's winner from the holding status and the stored owner.
    always_comb begin
        if (l_held && r_held) begin
            winner = owner_q;
        end else if (r_held && !l_held) begin
            winner = SIDE_RIGHT;
        end else begin
            winner = SIDE_LEFT;
        end
    end

    // Keep the winner so a continuing collision does not change hands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= SIDE_LEFT;
        end else begin
            owner_q <= winner;
        end
    end

    // Drive busy to the losing side and the combined flag.
    always_comb begin
        l_busy_n = !(match && winner == SIDE_RIGHT);
        r_busy_n = !(match && winner == SIDE_LEFT);
        collide  = !l_busy_n || !r_busy_n;
    end

    // R3: never both busy.
    p_busy_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    // R1: no busy without a live same-address match.
    p_idle_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en || !r_en || l_addr != r_addr) |-> (l_busy_n && r_busy_n));

    // R4: a fresh collision with no single incumbent goes to the left port.
    p_tie_left_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_addr == r_addr && !l_held && !r_held) |-> (l_busy_n && !r_busy_n));

    // R2: an incumbent right port beats a newcomer on the left.
    p_incumbent_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_addr == r_addr && r_held && !l_held) |-> (!l_busy_n && r_busy_n));

    // R7: with both ports holding, the busy side of last cycle stays busy.
    p_owner_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_held && r_held && $past(!r_busy_n)) |-> !r_busy_n);
endmodule

// File: rtl/dpca_port_array.sv
// Behavioural two-port byte array with registered reads. A port writes only
// when enabled, its strobe is low and its busy is high; reads return the
// byte as it stood before the same edge's writes.
module dpca_port_array
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0]                 p_en,
    input  logic [NUM_PORTS-1:0]                 p_wr_n,
    input  logic [NUM_PORTS-1:0]                 p_busy_n,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     p_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]     p_wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]     p_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0]    mem [DEPTH];
    logic [NUM_PORTS-1:0] we;

    // Gate each port's write with its busy indication.
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            we[i] = p_en[i] && !p_wr_n[i] && p_busy_n[i];
        end
    end

    // Store accepted writes; the arbiter guarantees distinct addresses.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (we[i]) begin
                mem[p_addr[i]] <= p_wdata[i];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_read
            // Registered read on an enabled non-write cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    p_rdata[g] <= '0;
                end else if (p_en[g] && p_wr_n[g]) begin
                    p_rdata[g] <= mem[p_addr[g]];
                end
            end
        end
    endgenerate

    // R5: two accepted writes never target the same byte.
    p_single_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] && we[1]) |-> (p_addr[0] != p_addr[1]));
endmodule

// File: rtl/dpca_top.sv
// Top level: two arrival trackers, the contention decision and the gated
// byte array. Port 0 of the array is the left port, port 1 the right.
module dpca_top #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n,
    input  logic              r_en,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n,
    output logic              collide
);
    logic l_held;
    logic r_held;
    logic [1:0][DATA_W-1:0] rdata_v;

    dpca_arrival_tracker #(.ADDR_W(ADDR_W)) u_l_track (
        .clk(clk), .rst_n(rst_n), .en(l_en), .addr(l_addr), .held(l_held)
    );

    dpca_arrival_tracker #(.ADDR_W(ADDR_W)) u_r_track (
        .clk(clk), .rst_n(rst_n), .en(r_en), .addr(r_addr), .held(r_held)
    );

    dpca_contention #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_addr(l_addr), .l_held(l_held),
        .r_en(r_en), .r_addr(r_addr), .r_held(r_held),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .collide(collide)
    );

    dpca_port_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .p_en({r_en, l_en}),
        .p_wr_n({r_wr_n, l_wr_n}),
        .p_busy_n({r_busy_n, l_busy_n}),
        .p_addr({r_addr, l_addr}),
        .p_wdata({r_wdata, l_wdata}),
        .p_rdata(rdata_v)
    );

    // Split the packed read data back onto the named ports.
    always_comb begin
        l_rdata = rdata_v[0];
        r_rdata = rdata_v[1];
    end

    // R9: the combined flag follows the busy outputs.
    p_collide_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        collide == (!l_busy_n || !r_busy_n));
endmodule

// File: tb/dpca_top_tb_top.sv
module dpca_top_tb_top;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_wr_n = 1, r_en = 0, r_wr_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_n, r_busy_n, collide;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_lrd = '0, m_rrd = '0;
    bit m_pl_en = 0, m_pr_en = 0;
    int m_pl_addr = 0, m_pr_addr = 0;
    int m_owner = 0;  // 0 left, 1 right

    always #4 clk = ~clk;

    dpca_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_n(l_busy_n),
        .r_en(r_en), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_n(r_busy_n), .collide(collide)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive, check busy/collide, clock, update model, check read data.
    task automatic step(string tag, bit le, bit lw_n, int la, int ld,
                        bit re, bit rw_n, int ra, int rd);
        bit match, lh, rh, elb, erb;
        int win;
        @(negedge clk);
        l_en = le; l_wr_n = lw_n; l_addr = AW'(la); l_wdata = DW'(ld);
        r_en = re; r_wr_n = rw_n; r_addr = AW'(ra); r_wdata = DW'(rd);
        #1;
        match = le && re && (la == ra);
        lh = le && m_pl_en && (la == m_pl_addr);
        rh = re && m_pr_en && (ra == m_pr_addr);
        if (lh && rh) win = m_owner;
        else if (rh && !lh) win = 1;
        else win = 0;
        elb = !(match && win == 1);
        erb = !(match && win == 0);
        check(tag, "l_busy_n", int'(l_busy_n), int'(elb));
        check(tag, "r_busy_n", int'(r_busy_n), int'(erb));
        check("R9", "collide", int'(collide), int'(!elb || !erb));
        @(posedge clk);
        #1;
        if (le && lw_n) m_lrd = m_mem[la];
        if (re && rw_n) m_rrd = m_mem[ra];
        if (le && !lw_n && elb) m_mem[la] = DW'(ld);
        if (re && !rw_n && erb) m_mem[ra] = DW'(rd);
        m_owner = win;
        m_pl_en = le; m_pl_addr = la;
        m_pr_en = re; m_pr_addr = ra;
        check(tag, "l_rdata", int'(l_rdata), int'(m_lrd));
        check(tag, "r_rdata", int'(r_rdata), int'(m_rrd));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R10: reset state
        check("R1", "l_busy_n reset", int'(l_busy_n), 1);
        check("R1", "r_busy_n reset", int'(r_busy_n), 1);
        check("R10", "l_rdata reset", int'(l_rdata), 0);
        check("R10", "r_rdata reset", int'(r_rdata), 0);

        // R10: fill the whole array from the left port, right idle
        for (int a = 0; a < DEPTH; a++) step("R10", 1, 0, a, (a * 7 + 3) & 8'hff, 0, 1, 0, 0);
        // R1: reads at different addresses, no busy
        step("R1", 1, 1, 10, 0, 1, 1, 11, 0);
        step("R10", 1, 1, 12, 0, 1, 1, 13, 0);
        step("R1", 0, 1, 20, 0, 1, 1, 20, 0);

        // R2: left holds 5, right arrives; right write must be ignored (R5)
        step("R2", 1, 1, 5, 0, 0, 1, 0, 0);
        step("R2", 1, 1, 5, 0, 1, 0, 5, 8'hAA);
        step("R5", 1, 1, 5, 0, 1, 0, 5, 8'hBB);
        // R7: stays with left; left writes land, right reads still served (R8)
        step("R7", 1, 0, 5, 8'h5C, 1, 1, 5, 0);
        step("R8", 1, 1, 5, 0, 1, 1, 5, 0);
        // R6: release by address change
        step("R6", 1, 1, 5, 0, 1, 1, 6, 0);
        // R2: right holds 6, left arrives and its write is ignored (R5)
        step("R2", 1, 0, 6, 8'h11, 1, 1, 6, 0);
        step("R5", 1, 1, 6, 0, 1, 1, 6, 0);
        // R6: release by enable drop
        step("R6", 1, 1, 6, 0, 0, 1, 6, 0);
        step("R6", 0, 1, 6, 0, 0, 1, 6, 0);
        // R4: tie from idle, left wins; right write blocked
        step("R4", 1, 1, 30, 0, 1, 0, 30, 8'h77);
        step("R7", 1, 1, 30, 0, 1, 1, 30, 0);
        // R4: both move together to a new equal address
        step("R4", 1, 1, 31, 0, 1, 0, 31, 8'h66);
        step("R8", 1, 1, 31, 0, 1, 1, 31, 0);
        // R7: right incumbent keeps winning after left re-arrives and holds
        step("R2", 0, 1, 0, 0, 1, 1, 40, 0);
        step("R2", 1, 0, 40, 8'h99, 1, 1, 40, 0);
        step("R7", 1, 0, 40, 8'h98, 1, 1, 40, 0);
        step("R5", 1, 1, 40, 0, 1, 1, 40, 0);

        // R3: random traffic on four addresses
        for (int i = 0; i < 600; i++) begin
            step("R3", bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
                 bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule